// File: doc/BRIEF.md
# Replay-Capable Synchronous FIFO

This block is a single-clock FIFO buffer with a small inferred storage array. It can record a read position and later rewind to it, so that a stretch of data can be delivered a second time. A typical user is a link layer that sends a frame, keeps the frame start marked until the far end acknowledges it, and rewinds to that start to resend the frame when the far end asks for it.

The read side works in one of two timing modes. The mode is captured while master reset is held. In standard mode the output register changes only when a read is requested, and the two status outputs report empty and full. In fall-through mode the oldest word is presented on the output without a request, and the same two status outputs report output-ready and input-ready. A partial reset empties the buffer and drops the mark. It keeps the captured mode.

While a mark is held, writes cannot overwrite any slot from the mark onward, so the mark can always be rewound to. A rewind consumes the mark. All status outputs are active high.

Top module: `rtx_fifo`

## Requirements
- R1: While `mrst` is high, each rising edge loads the timing mode from `fwft_sel` (0 = standard, 1 = fall-through). A partial reset leaves the mode unchanged, and so does any later value on `fwft_sel`.
- R2: In standard mode, a written word does not reach `rd_data` until a read is made. A read is `rd_en` high at a rising edge while the buffer is not empty. It loads the oldest unread word into `rd_data`, which is visible just after that edge.
- R3: In fall-through mode, a word written into an empty buffer at edge N is presented on `rd_data` with `stat_out` high after edge N+1, with no read request. Each `rd_en` while ready consumes the presented word. The next word follows after the same edge if one is stored; otherwise `stat_out` falls.
- R4: In standard mode, `stat_out` is the empty flag and `stat_in` is the full flag. In fall-through mode, `stat_out` is output-ready and `stat_in` is the inverse of full.
- R5: `mark` high at an edge records the location of the word that a read at that edge would deliver. In standard mode this is the next unread word. In fall-through mode it is the presented word when one is ready.
- R6: `retx` high at an edge while a mark is held moves the read position back to the mark. The mark is cleared. Any read or new mark at that same edge is dropped. In fall-through mode, output-ready falls and the marked word is presented again after the following edge.
- R7: Full means DEPTH words are held, counted from the mark when one is held. Otherwise the count starts at the oldest word not yet consumed; in fall-through mode that includes the presented word.
- R8: `retx` with no mark held has no effect. A read or mark at the same edge proceeds as if `retx` were low.
- R9: A read while the buffer is empty leaves `rd_data` and the read position unchanged. A write while full is dropped.
- R10: `mrst` or `prst` high at an edge empties the buffer, clears the mark and output-ready, and zeroes `rd_data`. Reset has priority over every other input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| mrst | input | 1 | Synchronous master reset; loads the mode |
| prst | input | 1 | Synchronous partial reset; keeps the mode |
| fwft_sel | input | 1 | Mode select sampled during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request (standard) / consume (fall-through) |
| mark | input | 1 | Record the current read location |
| retx | input | 1 | Rewind the read position to the mark |
| rd_data | output | WIDTH | Output data register |
| stat_out | output | 1 | Empty (standard) or output-ready (fall-through) |
| stat_in | output | 1 | Full (standard) or input-ready (fall-through) |

## Verification
Write effects and status-flag changes appear directly after the edge that makes them, since the flags are decoded from registered pointers. A standard-mode read shows on `rd_data` after the edge on which it is made. A fall-through word written into an empty buffer needs one further edge before it is presented. The bench drives each cycle's inputs, advances a reference model across the same edge, and compares all outputs one time unit after that edge. The model holds its own count of words written, consumed and marked. Directed sequences pin down these latencies and the mark, rewind and reset cases. Pseudo-random sweeps in both modes cover mixed traffic with frequent full and empty conditions.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rtx_fifo_store.sv
module rtx_fifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rtx_fifo_ctrl.sv
module rtx_fifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          mode_fwft,
  input  logic          out_valid,
  input  logic          wr_en,
  input  logic          rd_pop,
  input  logic          mark_req,
  input  logic          retx_req,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] mark_ptr,
  output logic          mark_v,
  output logic          mem_empty,
  output logic          full,
  output logic          wr_fire,
  output logic          rtx_go
);
  // distance from an older pointer to a newer one, wrap-safe
  function automatic logic [PW-1:0] span(input logic [PW-1:0] newer,
                                         input logic [PW-1:0] older);
    return newer - older;
  endfunction

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return p + {{AW{1'b0}}, 1'b1};
  endfunction

  logic [PW-1:0] wptr_q, rptr_q, mark_q;
  logic          mark_v_q;
  logic [PW-1:0] cur_loc, base_loc;

  // location of the word a read would deliver now
  assign cur_loc   = rptr_q - {{AW{1'b0}}, (mode_fwft & out_valid)};
  assign base_loc  = mark_v_q ? mark_q : cur_loc;
  assign full      = (span(wptr_q, base_loc) == PW'(DEPTH));
  assign mem_empty = (wptr_q == rptr_q);
  assign wr_fire   = wr_en & ~full;
  assign rtx_go    = retx_req & mark_v_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      mark_q   <= '0;
      mark_v_q <= 1'b0;
    end else begin
      if (wr_fire) wptr_q <= bump(wptr_q);
      if (rtx_go) begin
        rptr_q   <= mark_q;
        mark_v_q <= 1'b0;
      end else begin
        if (rd_pop) rptr_q <= bump(rptr_q);
        if (mark_req) begin
          mark_q   <= cur_loc;
          mark_v_q <= 1'b1;
        end
      end
    end
  end

  assign wptr     = wptr_q;
  assign rptr     = rptr_q;
  assign mark_ptr = mark_q;
  assign mark_v   = mark_v_q;
endmodule

// File: rtl/rtx_fifo_out.sv
module rtx_fifo_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             mode_fwft,
  input  logic             rd_en,
  input  logic             mem_empty,
  input  logic             rtx_go,
  input  logic [WIDTH-1:0] mem_word,
  output logic             pop,
  output logic             out_valid,
  output logic [WIDTH-1:0] rd_data
);
  logic             ov_q;
  logic [WIDTH-1:0] data_q;

  assign pop = ~rtx_go & ~mem_empty & (mode_fwft ? (~ov_q | rd_en) : rd_en);

  always_ff @(posedge clk) begin
    if (clr) begin
      ov_q   <= 1'b0;
      data_q <= '0;
    end else begin
      if (pop) data_q <= mem_word;
      if (mode_fwft) begin
        if (rtx_go)     ov_q <= 1'b0;
        else if (pop)   ov_q <= 1'b1;
        else if (rd_en) ov_q <= 1'b0;
      end
    end
  end

  assign out_valid = ov_q;
  assign rd_data   = data_q;
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
  import rtx_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prst,
  input  logic             fwft_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             mark,
  input  logic             retx,
  output logic [WIDTH-1:0] rd_data,
  output logic             stat_out,
  output logic             stat_in
);
  rd_mode_e         mode_q;
  logic             mode_fwft;
  logic             clr;
  logic [PW-1:0]    wptr, rptr, mark_ptr;
  logic             mark_v, mem_empty, full, wr_fire, rtx_go;
  logic             rd_pop, out_valid;
  logic [WIDTH-1:0] mem_word;

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= fwft_sel ? MODE_FWFT : MODE_STD;
  end

  assign mode_fwft = (mode_q == MODE_FWFT);
  assign clr       = mrst | prst;

  rtx_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .clr(clr), .mode_fwft(mode_fwft), .out_valid(out_valid),
    .wr_en(wr_en), .rd_pop(rd_pop), .mark_req(mark), .retx_req(retx),
    .wptr(wptr), .rptr(rptr), .mark_ptr(mark_ptr), .mark_v(mark_v),
    .mem_empty(mem_empty), .full(full), .wr_fire(wr_fire), .rtx_go(rtx_go)
  );

  rtx_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
    .clk(clk), .we(wr_fire), .waddr(wptr[AW-1:0]), .wdata(wr_data),
    .raddr(rptr[AW-1:0]), .rdata(mem_word)
  );

  rtx_fifo_out #(.WIDTH(WIDTH)) out_i (
    .clk(clk), .clr(clr), .mode_fwft(mode_fwft), .rd_en(rd_en),
    .mem_empty(mem_empty), .rtx_go(rtx_go), .mem_word(mem_word),
    .pop(rd_pop), .out_valid(out_valid), .rd_data(rd_data)
  );

  assign stat_out = mode_fwft ? out_valid : mem_empty;
  assign stat_in  = mode_fwft ? ~full : full;
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input logic          clk,
  input logic          mrst,
  input logic          prst,
  input logic          mode_fwft,
  input logic          wr_en,
  input logic          rd_en,
  input logic          retx,
  input logic          rd_pop,
  input logic          out_valid,
  input logic          mem_empty,
  input logic          full,
  input logic          mark_v,
  input logic [PW-1:0] mark_ptr,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr
);
  logic [PW-1:0] oldest_c, held_c;
  assign oldest_c = mark_v ? mark_ptr : (rptr - {{AW{1'b0}}, (mode_fwft & out_valid)});
  assign held_c   = wptr - oldest_c;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    full && wr_en |=> $stable(wptr));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    mem_empty && rd_en && !(retx && mark_v) |=> $stable(rptr));

  // R8
  retx_nomark_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    retx && !mark_v && !rd_pop |=> $stable(rptr));

  // R6
  rewind_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    retx && mark_v |=> (rptr == $past(mark_ptr)) && !mark_v);

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> $stable(mode_fwft));

  // R7
  capacity_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    held_c <= PW'(DEPTH));

  // R3
  ready_src_chk: assert property (@(posedge clk) disable iff (mrst || prst)
    $rose(out_valid) |-> $past(!mem_empty));
endmodule

bind rtx_fifo rtx_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .mrst(mrst), .prst(prst), .mode_fwft(mode_fwft),
  .wr_en(wr_en), .rd_en(rd_en), .retx(retx), .rd_pop(rd_pop),
  .out_valid(out_valid), .mem_empty(mem_empty), .full(full),
  .mark_v(mark_v), .mark_ptr(mark_ptr), .wptr(wptr), .rptr(rptr)
);

// File: tb/rtx_fifo_tb_top.sv
module rtx_fifo_tb_top;
  localparam int W = 8;
  localparam int D = 4;
  localparam int CLK_PERIOD = 10;
  localparam int HN = 1024;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0, mark = 1'b0, retx = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         stat_out, stat_in;

  rtx_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .mark(mark),
    .retx(retx), .rd_data(rd_data), .stat_out(stat_out), .stat_in(stat_in)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // reference model: absolute counts of words written / consumed
  int       wc, rc, mki;
  bit       mk, ov, fw;
  logic [W-1:0] outd;
  logic [W-1:0] hist [HN];
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cur_loc();
    return (fw && ov) ? rc - 1 : rc;
  endfunction

  function automatic bit m_full();
    int base;
    base = mk ? mki : cur_loc();
    return (wc - base) == D;
  endfunction

  // R4: flag meanings per mode; R2/R3 data checks
  task automatic verify(input string req);
    bit emp;
    emp = (wc == rc);
    if (!fw) begin
      chk(req, "stat_out(empty)", int'(stat_out), int'(emp));
      chk(req, "stat_in(full)", int'(stat_in), int'(m_full()));
      chk(req, "rd_data", int'(rd_data), int'(outd));
    end else begin
      chk(req, "stat_out(ready)", int'(stat_out), int'(ov));
      chk(req, "stat_in(ready)", int'(stat_in), int'(!m_full()));
      if (ov) chk(req, "rd_data", int'(rd_data), int'(outd));
    end
  endtask

  task automatic model_step(input bit w, input logic [W-1:0] d, input bit r,
                            input bit m, input bit x);
    bit emp, fl;
    int cl;
    emp = (wc == rc);
    fl  = m_full();
    cl  = cur_loc();
    if (x && mk) begin
      rc = mki; mk = 1'b0;
      if (fw) ov = 1'b0;
    end else begin
      if (m) begin mk = 1'b1; mki = cl; end
      if (!fw) begin
        if (r && !emp) begin outd = hist[rc % HN]; rc++; end
      end else begin
        if (!emp && (!ov || r)) begin outd = hist[rc % HN]; rc++; ov = 1'b1; end
        else if (r) ov = 1'b0;
      end
    end
    if (w && !fl) begin hist[wc % HN] = d; wc++; end
  endtask

  task automatic cyc(input bit w, input logic [W-1:0] d, input bit r,
                     input bit m, input bit x, input string req);
    wr_en = w; wr_data = d; rd_en = r; mark = m; retx = x;
    model_step(w, d, r, m, x);
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0; mark = 1'b0; retx = 1'b0;
    verify(req);
  endtask

  task automatic do_reset(input bit master, input bit sel, input string req);
    fwft_sel = sel;
    wr_en = 1'b0; rd_en = 1'b0; mark = 1'b0; retx = 1'b0;
    if (master) mrst = 1'b1; else prst = 1'b1;
    @(posedge clk); #1;
    mrst = 1'b0; prst = 1'b0;
    if (master) fw = sel;
    wc = 0; rc = 0; mk = 1'b0; ov = 1'b0; outd = '0;
    verify(req);
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic sweep(input bit sel, input int n);
    int unsigned v;
    do_reset(1'b1, sel, "R10");
    for (int i = 0; i < n; i++) begin
      v = rnd();
      if (v % 97 == 3) begin
        do_reset(1'b0, 1'b0, "R10");  // partial reset; R1 mode kept
      end else begin
        cyc(v[0] | v[1], W'(v >> 4), v[2] | (v[3] & v[12]),
            (v[14:10] == 5'd0), (v[19:16] == 4'd1), "R7");
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R10: reset state in standard mode
    do_reset(1'b1, 1'b0, "R10");
    chk("R10", "rd_data after reset", int'(rd_data), 0);
    chk("R4", "empty after reset", int'(stat_out), 1);

    // R2: written word stays hidden until a read
    cyc(1, 8'hA1, 0, 0, 0, "R2");
    chk("R2", "rd_data before read", int'(rd_data), 0);
    cyc(0, 0, 1, 0, 0, "R2");
    chk("R2", "rd_data after read", int'(rd_data), 8'hA1);

    // R9: fill past capacity, then drain past empty
    for (int i = 0; i < D + 2; i++) cyc(1, W'(8'h20 + i), 0, 0, 0, "R9");
    chk("R9", "full flag", int'(stat_in), 1);
    for (int i = 0; i < D + 2; i++) cyc(0, 0, 1, 0, 0, "R9");
    chk("R9", "rd_data held at last word", int'(rd_data), 8'h23);

    // R5/R6: mark on read of 0x31, rewind replays it
    cyc(1, 8'h31, 0, 0, 0, "R5");
    cyc(1, 8'h32, 0, 0, 0, "R5");
    cyc(1, 8'h33, 1, 1, 0, "R5");
    cyc(0, 0, 1, 0, 0, "R5");
    cyc(0, 0, 1, 0, 1, "R6");
    cyc(0, 0, 1, 0, 0, "R6");
    chk("R6", "replayed word", int'(rd_data), 8'h31);
    // R8: mark consumed, a second rewind does nothing
    cyc(0, 0, 0, 0, 1, "R8");
    cyc(0, 0, 1, 0, 0, "R8");
    chk("R8", "read after ignored rewind", int'(rd_data), 8'h32);

    // R7: with mark at oldest word, capacity counted from mark
    cyc(0, 0, 0, 1, 0, "R7");
    for (int i = 0; i < D + 1; i++) cyc(1, W'(8'h40 + i), 1, 0, 0, "R7");
    chk("R7", "full held by mark", int'(stat_in), 1);

    // R3: fall-through latency
    do_reset(1'b1, 1'b1, "R10");
    cyc(1, 8'h5A, 0, 0, 0, "R3");
    chk("R3", "not ready on write edge", int'(stat_out), 0);
    cyc(0, 0, 0, 0, 0, "R3");
    chk("R3", "ready one edge later", int'(stat_out), 1);
    chk("R3", "presented word", int'(rd_data), 8'h5A);
    cyc(0, 0, 1, 0, 0, "R3");
    chk("R3", "ready falls when drained", int'(stat_out), 0);

    // R1: partial reset keeps fall-through mode despite fwft_sel low
    do_reset(1'b0, 1'b0, "R1");
    cyc(1, 8'h66, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, "R1");
    chk("R1", "fall-through kept", int'(stat_out), 1);

    // R6: fall-through rewind to presented word
    cyc(1, 8'h67, 0, 1, 0, "R6");
    cyc(0, 0, 1, 0, 0, "R6");
    cyc(0, 0, 0, 0, 1, "R6");
    chk("R6", "ready drops on rewind", int'(stat_out), 0);
    cyc(0, 0, 0, 0, 0, "R6");
    chk("R6", "marked word again", int'(rd_data), 8'h66);

    sweep(1'b0, 700);
    sweep(1'b1, 700);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule